// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block is the digital control core of a dual-slope integrating analog-to-digital converter. It steps the analog front end through four phases and drives one select line per phase: offset nulling (auto-zero), a fixed-length integration of the input signal, de-integration against a reference, and a short phase that forces the integrator back to zero. One shared counter times every phase. During de-integration the block watches the comparator and stops the count when the comparator output changes level. The count at that point, the input polarity and an over-range flag then go into a result register.

A status output shows when a conversion is in progress, so that a reader of the result knows when to keep away from the register. A run/hold input can stop the sequencer in auto-zero between conversions. The output logic can block the result update with an inhibit input while it is still sending an earlier result. The analog integrator is outside this block.

Top module: `dslope_seq`

## Requirements
- R1: After reset, only the auto-zero select `az_o` is high, `status_o` is low and `result_o` is zero.
- R2: Exactly one phase select is high in every cycle. The phases always follow the order auto-zero, integrate, de-integrate, zero-integrator, then auto-zero again.
- R3: The integrate phase lasts exactly 2**(CNT_W-1) clock cycles. This is 2048 with the default width.
- R4: The comparator passes through a two-flop synchronizer. A zero crossing is a synchronized level that differs from the level held on the edge that ends integration. De-integration ends on the first edge where a crossing is present. The count field `result_o[CNT_W-1:0]` receives the number of de-integrate cycles that came before that edge. The over-range bit `result_o[CNT_W+1]` is cleared.
- R5: If no crossing is seen, de-integration lasts 2**CNT_W cycles (4096 with the default width). The result then gets the over-range bit `result_o[CNT_W+1]` set and a count field of all ones. A crossing found in the last de-integrate cycle still counts as a normal result.
- R6: The polarity bit `result_o[CNT_W]` holds the value of `pol_i` on the edge that ends the integrate phase.
- R7: The zero-integrator phase lasts ZI_LEN cycles, and then auto-zero begins.
- R8: `status_o` rises on the edge that enters integration and falls on the edge that ends de-integration. `result_o` changes on no other edge.
- R9: With `run_hold_i` high, auto-zero lasts AZ_LEN cycles. If `run_hold_i` is low when auto-zero would end, the block stays in auto-zero. The value of `run_hold_i` during the other phases has no effect.
- R10: When the block leaves hold, integration begins on the (START_DLY+1)-th rising edge in a row at which `run_hold_i` is sampled high. With the default START_DLY of 7 this is the 8th edge.
- R11: If `inhibit_i` is high on the edge that ends de-integration, `result_o` keeps its previous value, and `status_o` still falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| comp_i | input | 1 | Comparator output, asynchronous |
| pol_i | input | 1 | Input polarity sense |
| run_hold_i | input | 1 | High to convert continuously, low to hold in auto-zero |
| inhibit_i | input | 1 | Blocks the result update while the output logic is busy |
| az_o | output | 1 | Auto-zero phase select |
| int_o | output | 1 | Signal-integrate phase select |
| de_o | output | 1 | De-integrate phase select |
| zi_o | output | 1 | Zero-integrator phase select |
| status_o | output | 1 | High while a conversion is in progress |
| result_o | output | CNT_W+2 | {over-range, polarity, count} |

## Verification
The hardest case to reach is the boundary of de-integration. Here a comparator change arrives so late that only the synchronizer delay decides whether the result is a full-scale count or an over-range. The bench toggles the comparator at a chosen de-integrate cycle, measured from the cycle the select rises. It uses the cycle two before the last to get a normal result at the top count, and the cycle one before the last to get an over-range. A second hard case is hold. The bench drops run/hold only once integration has started, checks that the conversion runs to its end anyway, and then counts the edges from the release of hold to the start of integration.

// File: rtl/dslope_pkg.sv
package dslope_pkg;

   typedef enum logic [1:0] {
      PH_AZ  = 2'd0,
      PH_INT = 2'd1,
      PH_DE  = 2'd2,
      PH_ZI  = 2'd3
   } phase_e;

endpackage

// File: rtl/dslope_sync.sv
module dslope_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dslope_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shreg <= '0;
      else        shreg <= {shreg[STAGES-2:0], d_i};
   end

   assign q_o = shreg[STAGES-1];

endmodule

// File: rtl/dslope_fsm.sv
module dslope_fsm
   import dslope_pkg::*;
#(
   parameter int CNT_W     = 12,
   parameter int AZ_LEN    = 1790,
   parameter int ZI_LEN    = 32,
   parameter int START_DLY = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_hold_i,
   input  logic             cmp_s_i,
   output phase_e           phase_o,
   output logic             int_start_o,
   output logic             int_end_o,
   output logic             de_end_o,
   output logic             over_o,
   output logic [CNT_W-1:0] count_o
);

   localparam int RW = $clog2(START_DLY + 1);
   localparam logic [CNT_W-1:0] INT_LAST = CNT_W'(2**(CNT_W-1) - 1);
   localparam logic [CNT_W-1:0] DE_LAST  = CNT_W'(2**CNT_W - 1);
   localparam logic [CNT_W-1:0] AZ_LAST  = CNT_W'(AZ_LEN - 1);
   localparam logic [CNT_W-1:0] ZI_LAST  = CNT_W'(ZI_LEN - 1);
   localparam logic [RW-1:0]    RUN_FULL = RW'(START_DLY);

   phase_e           phase;
   logic [CNT_W-1:0] cnt;
   logic [RW-1:0]    run_cnt;
   logic             ref_lvl;
   logic             crossing;
   logic             az_ready;
   logic             zi_end;

   always_comb begin
      crossing = (phase == PH_DE) && (cmp_s_i != ref_lvl);
      az_ready = (phase == PH_AZ) && (cnt == AZ_LAST) && run_hold_i
                 && (run_cnt == RUN_FULL);
      int_end_o = (phase == PH_INT) && (cnt == INT_LAST);
      de_end_o  = (phase == PH_DE) && (crossing || (cnt == DE_LAST));
      over_o    = de_end_o && !crossing;
      zi_end    = (phase == PH_ZI) && (cnt == ZI_LAST);
   end

   // consecutive-high counter for leaving hold
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                run_cnt <= '0;
      else if (!run_hold_i)      run_cnt <= '0;
      else if (run_cnt != RUN_FULL) run_cnt <= run_cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_AZ;
         cnt     <= '0;
         ref_lvl <= 1'b0;
      end else begin
         unique case (phase)
            PH_AZ: begin
               if (az_ready) begin
                  phase <= PH_INT;
                  cnt   <= '0;
               end else if (cnt != AZ_LAST) begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_INT: begin
               if (int_end_o) begin
                  phase   <= PH_DE;
                  cnt     <= '0;
                  ref_lvl <= cmp_s_i;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_DE: begin
               if (de_end_o) begin
                  phase <= PH_ZI;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_ZI: begin
               if (zi_end) begin
                  phase <= PH_AZ;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               phase <= PH_AZ;
               cnt   <= '0;
            end
         endcase
      end
   end

   assign phase_o     = phase;
   assign int_start_o = az_ready;
   assign count_o     = cnt;

endmodule

// File: rtl/dslope_capture.sv
module dslope_capture #(
   parameter int CNT_W = 12,
   localparam int RES_W = CNT_W + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             int_start_i,
   input  logic             int_end_i,
   input  logic             de_end_i,
   input  logic             over_i,
   input  logic [CNT_W-1:0] count_i,
   input  logic             pol_i,
   input  logic             inhibit_i,
   output logic             status_o,
   output logic [RES_W-1:0] result_o
);

   logic pol_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pol_q <= 1'b0;
      else if (int_end_i) pol_q <= pol_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           status_o <= 1'b0;
      else if (int_start_i) status_o <= 1'b1;
      else if (de_end_i)    status_o <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_o <= '0;
      end else if (de_end_i && !inhibit_i) begin
         result_o <= {over_i, pol_q, over_i ? {CNT_W{1'b1}} : count_i};
      end
   end

endmodule

// File: rtl/dslope_seq.sv
module dslope_seq
   import dslope_pkg::*;
#(
   parameter int CNT_W       = 12,
   parameter int AZ_LEN      = 1790,
   parameter int ZI_LEN      = 32,
   parameter int START_DLY   = 7,
   parameter int SYNC_STAGES = 2,
   localparam int RES_W      = CNT_W + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             comp_i,
   input  logic             pol_i,
   input  logic             run_hold_i,
   input  logic             inhibit_i,
   output logic             az_o,
   output logic             int_o,
   output logic             de_o,
   output logic             zi_o,
   output logic             status_o,
   output logic [RES_W-1:0] result_o
);

   generate
      if (CNT_W < 4 || CNT_W > 20) begin : g_bad_width
         $error("dslope_seq: CNT_W out of range 4..20");
      end
      if (AZ_LEN < 1 || AZ_LEN > 2**CNT_W) begin : g_bad_az
         $error("dslope_seq: AZ_LEN must fit the phase counter");
      end
      if (ZI_LEN < 1 || ZI_LEN > 2**CNT_W) begin : g_bad_zi
         $error("dslope_seq: ZI_LEN must fit the phase counter");
      end
      if (START_DLY < 1) begin : g_bad_dly
         $error("dslope_seq: START_DLY must be at least 1");
      end
   endgenerate

   logic             cmp_s;
   phase_e           phase;
   logic             int_start;
   logic             int_end;
   logic             de_end;
   logic             over;
   logic [CNT_W-1:0] count;

   dslope_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (comp_i),
      .q_o   (cmp_s)
   );

   dslope_fsm #(
      .CNT_W     (CNT_W),
      .AZ_LEN    (AZ_LEN),
      .ZI_LEN    (ZI_LEN),
      .START_DLY (START_DLY)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .run_hold_i  (run_hold_i),
      .cmp_s_i     (cmp_s),
      .phase_o     (phase),
      .int_start_o (int_start),
      .int_end_o   (int_end),
      .de_end_o    (de_end),
      .over_o      (over),
      .count_o     (count)
   );

   dslope_capture #(.CNT_W(CNT_W)) u_cap (
      .clk         (clk),
      .rst_n       (rst_n),
      .int_start_i (int_start),
      .int_end_i   (int_end),
      .de_end_i    (de_end),
      .over_i      (over),
      .count_i     (count),
      .pol_i       (pol_i),
      .inhibit_i   (inhibit_i),
      .status_o    (status_o),
      .result_o    (result_o)
   );

   assign az_o  = (phase == PH_AZ);
   assign int_o = (phase == PH_INT);
   assign de_o  = (phase == PH_DE);
   assign zi_o  = (phase == PH_ZI);

endmodule

// File: rtl/dslope_seq_chk.sv
module dslope_seq_chk #(
   parameter int CNT_W = 12,
   localparam int RES_W = CNT_W + 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             az,
   input logic             int_ph,
   input logic             de,
   input logic             zi,
   input logic             status,
   input logic             run_hold,
   input logic [RES_W-1:0] result
);

   localparam logic [CNT_W:0] INT_LEN = (CNT_W+1)'(2**(CNT_W-1));
   localparam logic [CNT_W:0] DE_MAX  = (CNT_W+1)'(2**CNT_W);

   logic [CNT_W:0] int_run;
   logic [CNT_W:0] de_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         int_run <= '0;
         de_run  <= '0;
      end else begin
         int_run <= int_ph ? int_run + 1'b1 : '0;
         de_run  <= de     ? de_run + 1'b1  : '0;
      end
   end

   p_one_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({az, int_ph, de, zi}) == 1);

   p_int_then_de_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(int_ph) |-> de);

   p_de_then_zi_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(de) |-> zi);

   p_int_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(int_ph) |-> (int_run == INT_LEN));

   p_de_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      de_run <= DE_MAX);

   p_status_at_int_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status) |-> int_ph);

   p_result_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(status) |-> $stable(result));

   p_hold_keeps_az_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (az && !run_hold) |=> az);

endmodule

bind dslope_seq dslope_seq_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .az       (az_o),
   .int_ph   (int_o),
   .de       (de_o),
   .zi       (zi_o),
   .status   (status_o),
   .run_hold (run_hold_i),
   .result   (result_o)
);

// File: tb/dslope_seq_bench.sv
`timescale 1ns/1ps
module dslope_seq_bench;

   localparam int CNT_W  = 6;
   localparam int AZ_LEN = 20;
   localparam int ZI_LEN = 8;
   localparam int DLY    = 7;
   localparam int RES_W  = CNT_W + 2;
   localparam int INT_N  = 2**(CNT_W-1);
   localparam int DE_N   = 2**CNT_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic comp_i = 1'b0;
   logic pol_i = 1'b0;
   logic run_hold_i = 1'b1;
   logic inhibit_i = 1'b0;
   logic az_o, int_o, de_o, zi_o, status_o;
   logic [RES_W-1:0] result_o;

   int n_checks = 0;
   int n_fails  = 0;
   int cycles   = 0;
   bit done     = 1'b0;
   logic [RES_W-1:0] exp_q[$];
   logic [RES_W-1:0] last_res = '0;

   always #2.5 clk = ~clk;

   dslope_seq #(
      .CNT_W     (CNT_W),
      .AZ_LEN    (AZ_LEN),
      .ZI_LEN    (ZI_LEN),
      .START_DLY (DLY)
   ) u_dslope_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .comp_i     (comp_i),
      .pol_i      (pol_i),
      .run_hold_i (run_hold_i),
      .inhibit_i  (inhibit_i),
      .az_o       (az_o),
      .int_o      (int_o),
      .de_o       (de_o),
      .zi_o       (zi_o),
      .status_o   (status_o),
      .result_o   (result_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   endtask

   // monitor: compares each latched result at the status fall
   bit prev_status = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_status && !status_o) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R4/R5/R11 unexpected result", int'(result_o), -1);
            end else begin
               logic [RES_W-1:0] e;
               e = exp_q.pop_front();
               check(result_o == e, "R4/R5/R6/R11 result", int'(result_o), int'(e));
            end
         end
         prev_status = status_o;
      end
   end

   // watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         check(1'b0, "watchdog", cycles, 100000);
         finish_up();
      end
   end

   // driver: one conversion; j<0 means the comparator never changes
   task automatic convert(input int j, input bit pol, input bit inh,
                          input bit meas_az, input bit drop_hold);
      int n;
      int k;
      logic [RES_W-1:0] e;
      pol_i = pol;
      inhibit_i = inh;
      while (!int_o) @(negedge clk);
      check(status_o == 1'b1, "R8 status high in integrate", status_o, 1);
      if (drop_hold) run_hold_i = 1'b0;
      n = 0;
      while (int_o) begin n++; @(negedge clk); end
      check(n == INT_N, "R3 integrate length", n, INT_N);
      check(de_o == 1'b1, "R2 de follows integrate", de_o, 1);
      if (j >= 0 && j + 2 <= DE_N - 1) e = {1'b0, pol, CNT_W'(j + 2)};
      else                             e = {1'b1, pol, {CNT_W{1'b1}}};
      if (inh) e = last_res;
      else     last_res = e;
      exp_q.push_back(e);
      k = 0;
      while (de_o) begin
         if (k == j) comp_i = ~comp_i;
         k++;
         @(negedge clk);
      end
      n = (j >= 0 && j + 2 <= DE_N - 1) ? j + 3 : DE_N;
      check(k == n, "R4/R5 de-integrate length", k, n);
      check(zi_o == 1'b1, "R2 zi follows de", zi_o, 1);
      check(status_o == 1'b0, "R8/R11 status low after de", status_o, 0);
      n = 0;
      while (zi_o) begin n++; @(negedge clk); end
      check(n == ZI_LEN, "R7 zero-integrator length", n, ZI_LEN);
      check(az_o == 1'b1, "R7 az follows zi", az_o, 1);
      inhibit_i = 1'b0;
      if (meas_az) begin
         n = 0;
         while (az_o) begin n++; @(negedge clk); end
         check(n == AZ_LEN, "R9 auto-zero length in run", n, AZ_LEN);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(az_o && !int_o && !de_o && !zi_o, "R1 reset phase", {az_o, int_o, de_o, zi_o}, 8);
      check(status_o == 1'b0, "R1 reset status", status_o, 0);
      check(result_o == '0, "R1 reset result", int'(result_o), 0);
      rst_n = 1'b1;

      convert(10, 1'b0, 1'b0, 1'b1, 1'b0);   // R4 mid-scale
      convert(0,  1'b1, 1'b0, 1'b0, 1'b0);   // R4 R6 immediate crossing
      convert(61, 1'b0, 1'b0, 1'b0, 1'b0);   // R5 crossing in last cycle
      convert(62, 1'b1, 1'b0, 1'b0, 1'b0);   // R5 just too late: over-range
      convert(-1, 1'b0, 1'b0, 1'b0, 1'b0);   // R5 no crossing
      convert(5,  1'b1, 1'b1, 1'b0, 1'b0);   // R11 inhibited
      convert(20, 1'b0, 1'b0, 1'b0, 1'b1);   // R9 hold dropped mid-conversion

      begin : hold_phase
         int n;
         repeat (60) @(negedge clk);
         check(az_o == 1'b1, "R9 held in auto-zero", az_o, 1);
         check(status_o == 1'b0, "R9 status low in hold", status_o, 0);
         check(result_o == last_res, "R11 result after hold", int'(result_o), int'(last_res));
         run_hold_i = 1'b1;
         n = 0;
         while (!int_o && n < 50) begin @(negedge clk); n++; end
         check(n == DLY + 1, "R10 start delay after hold", n, DLY + 1);
      end

      convert(30, 1'b1, 1'b0, 1'b1, 1'b0);   // R4 R9 after release
      repeat (5) @(negedge clk);
      check(exp_q.size() == 0, "R8 all results observed", exp_q.size(), 0);
      finish_up();
   end

endmodule